// File: doc/BRIEF.md
# Multi-Port PHY Link Status Scanner

This block watches the link state of a group of Ethernet PHYs and keeps the speed setting of the matching MAC ports in step with them. It visits the ports one after another in ascending order. For each port it asks an external MDIO engine to read the PHY's vendor status register, using the port number as the PHY address. It then reduces the returned word to the three facts that matter: link, speed and duplex. It keeps that reduced word in a per-port store.

When the reduced word for a port differs from the stored one, the block updates the store and issues one write to that port's MAC interface-mode register through a simple register-bus write port. A link that is down is stored as all zeros. A down link still forces the fast (1 Gb/s) mode, so that transmit data queued for the port drains quickly. Between full scans the block pauses for a set number of cycles, and a scan only begins while the enable input is high. Per-port link, speed code and duplex outputs are decoded from the store, so the rest of the chip can read link state without any bus traffic.

Top module: `phy_link_scanner`

## Requirements
- R1: After reset every port reports link_up=0, full_duplex=0 and speed code 2. No MDIO read and no register write is requested until a scan starts.
- R2: A scan reads ports 0 to NPORTS-1 in ascending order. Each read uses PHY address equal to the port number and register address 0x11.
- R3: A request (mdio_req or reg_wr_req) stays high with stable address and data until its done/ack. At most one of the two requests is high at any time.
- R4: If bit 10 of the read word is 0, the port's reduced status is 0x0000. Otherwise it is the read word ANDed with 0xE400, which keeps bits 15, 14, 13 and 10. No other bit of the read word has any effect.
- R5: A register write is issued only when the reduced status differs from the value stored for that port. An unchanged port produces no write.
- R6: A write goes to address (port << 7) | 0x10. Its data is 0x0003 when the link is up and bit 15 is set, 0x0001 when the link is up and bit 15 is clear, and 0x0003 when the link is down.
- R7: A write follows directly after the read that found the change, before the next port is read.
- R8: Per port, link_up equals stored bit 10 and full_duplex equals stored bit 13. speed_code is 2 for a link that is up with bit 15 set, 1 for a link that is up with bit 15 clear, and 2 for a link that is down. A port's outputs take their new value one clock after the read of that port completes.
- R9: After a scan's last transaction completes, no new read is requested for at least IDLE_CYCLES cycles. The first scan after reset starts without that pause.
- R10: While scan_en is low no new scan starts. A scan already running completes.
- R11: The stored status resets to zero, so the first read after reset that shows a link up on a port always produces a write for that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk on release |
| scan_en | input | 1 | Allows a new scan to begin |
| mdio_req | output | 1 | MDIO read request, held until mdio_done |
| mdio_phy_addr | output | 5 | PHY address of the read |
| mdio_reg_addr | output | 5 | PHY register address of the read |
| mdio_done | input | 1 | One-cycle completion of the read |
| mdio_rdata | input | 16 | Read data, valid with mdio_done |
| reg_wr_req | output | 1 | Register write request, held until reg_wr_ack |
| reg_wr_addr | output | ADDR_W | Register write address |
| reg_wr_data | output | 16 | Register write data |
| reg_wr_ack | input | 1 | One-cycle completion of the write |
| link_up | output | NPORTS | Per-port link state |
| speed_code | output | 2*NPORTS | Per-port speed code, port i in bits [2i+1:2i] |
| full_duplex | output | NPORTS | Per-port duplex |

## Verification
The bench fills the don't-care bits of every read word with random values, and it sets words whose speed bits are set while bit 10 is clear. A design that masks wrongly, or that tests speed before link, would then write when nothing changed or report a speed for a dead port. A directed sequence after reset brings up ports at 1 Gb/s, at 100 Mb/s and with the reserved speed pair. A store that did not start at zero would miss those first writes, and a wrong decode would write 0x1 where 0x3 is due. The pause between scans and the enable gate are measured at the ports, which catches a scan that restarts early or ignores scan_en. A read issued while a write is still owed shows up as a write placed after the wrong port.

// File: rtl/pls_pkg.sv
package pls_pkg;

  localparam int unsigned STAT_W = 16;

  localparam logic [4:0]        PHY_STAT_REG   = 5'h11;
  localparam logic [STAT_W-1:0] STAT_KEEP_MASK = 16'hE400;
  localparam int unsigned       LINK_BIT       = 10;
  localparam int unsigned       SPD_HI_BIT     = 15;
  localparam int unsigned       DUPLEX_BIT     = 13;
  localparam logic [6:0]        SPEED_REG_OFS  = 7'h10;
  localparam logic [STAT_W-1:0] MODE_FAST      = 16'h0003;
  localparam logic [STAT_W-1:0] MODE_MID       = 16'h0001;
  localparam logic [1:0]        SPD_CODE_FAST  = 2'd2;
  localparam logic [1:0]        SPD_CODE_MID   = 2'd1;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_e;

  // Reduce a raw PHY status word to link/speed/duplex; a dead link is zero.
  function automatic logic [STAT_W-1:0] mask_status(input logic [STAT_W-1:0] raw);
    if (!raw[LINK_BIT]) return '0;
    return raw & STAT_KEEP_MASK;
  endfunction

  // MAC interface-mode value for a reduced status word.
  function automatic logic [STAT_W-1:0] mode_value(input logic [STAT_W-1:0] st);
    if (st[LINK_BIT] && !st[SPD_HI_BIT]) return MODE_MID;
    return MODE_FAST;
  endfunction

endpackage

// File: rtl/pls_sequencer.sv
module pls_sequencer
  import pls_pkg::*;
#(
  parameter int unsigned NPORTS      = 10,
  parameter int unsigned IDLE_CYCLES = 64,
  localparam int unsigned PORT_W     = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int unsigned GAP_W      = $clog2(IDLE_CYCLES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              mdio_done,
  input  logic              reg_wr_ack,
  input  logic              status_differs,
  output logic [PORT_W-1:0] cur_port,
  output logic              rd_active,
  output logic              wr_active,
  output logic              capture
);

  localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NPORTS - 1);
  localparam logic [GAP_W-1:0]  GAP_LOAD  = GAP_W'(IDLE_CYCLES);

  seq_state_e        state_q, state_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              seq_en;
  logic              advance;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    port_d  = port_q;
    gap_d   = gap_q;
    capture = 1'b0;
    advance = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (gap_q != '0) begin
          gap_d = gap_q - GAP_W'(1);
        end else if (scan_en) begin
          state_d = SEQ_READ;
          port_d  = '0;
        end
      end
      SEQ_READ: begin
        if (mdio_done) begin
          capture = 1'b1;
          if (status_differs) state_d = SEQ_WRITE;
          else                advance = 1'b1;
        end
      end
      SEQ_WRITE: begin
        if (reg_wr_ack) advance = 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase

    if (advance) begin
      if (port_q == LAST_PORT) begin
        state_d = SEQ_IDLE;
        gap_d   = GAP_LOAD;
      end else begin
        state_d = SEQ_READ;
        port_d  = port_q + PORT_W'(1);
      end
    end
  end

  assign seq_en = (state_d != state_q) || (port_d != port_q) || (gap_d != gap_q);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      port_q  <= '0;
      gap_q   <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      port_q  <= port_d;
      gap_q   <= gap_d;
    end
  end

  assign cur_port  = port_q;
  assign rd_active = (state_q == SEQ_READ);
  assign wr_active = (state_q == SEQ_WRITE);

endmodule

// File: rtl/pls_status_file.sv
module pls_status_file
  import pls_pkg::*;
#(
  parameter int unsigned NPORTS  = 10,
  localparam int unsigned PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [PORT_W-1:0]             wr_port,
  input  logic [STAT_W-1:0]             wr_status,
  input  logic [PORT_W-1:0]             rd_port,
  output logic [STAT_W-1:0]             rd_status,
  output logic [NPORTS-1:0][STAT_W-1:0] stat_all
);

  for (genvar i = 0; i < NPORTS; i++) begin : g_entry
    logic [STAT_W-1:0] stat_q;
    logic              entry_en;

    assign entry_en = wr_en && (wr_port == PORT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q <= '0;
      else if (entry_en) stat_q <= wr_status;
    end

    assign stat_all[i] = stat_q;
  end

  assign rd_status = stat_all[rd_port];

endmodule

// File: rtl/pls_port_report.sv
module pls_port_report
  import pls_pkg::*;
#(
  parameter int unsigned NPORTS = 10
) (
  input  logic [NPORTS-1:0][STAT_W-1:0] stat_all,
  output logic [NPORTS-1:0]             link_up,
  output logic [2*NPORTS-1:0]           speed_code,
  output logic [NPORTS-1:0]             full_duplex
);

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic lnk;
    assign lnk            = stat_all[i][LINK_BIT];
    assign link_up[i]     = lnk;
    assign full_duplex[i] = stat_all[i][DUPLEX_BIT];
    assign speed_code[2*i +: 2] =
      (lnk && !stat_all[i][SPD_HI_BIT]) ? SPD_CODE_MID : SPD_CODE_FAST;
  end

endmodule

// File: rtl/phy_link_scanner.sv
module phy_link_scanner
  import pls_pkg::*;
#(
  parameter int unsigned NPORTS      = 10,
  parameter int unsigned IDLE_CYCLES = 64,
  parameter int unsigned ADDR_W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_en,
  output logic                mdio_req,
  output logic [4:0]          mdio_phy_addr,
  output logic [4:0]          mdio_reg_addr,
  input  logic                mdio_done,
  input  logic [15:0]         mdio_rdata,
  output logic                reg_wr_req,
  output logic [ADDR_W-1:0]   reg_wr_addr,
  output logic [15:0]         reg_wr_data,
  input  logic                reg_wr_ack,
  output logic [NPORTS-1:0]   link_up,
  output logic [2*NPORTS-1:0] speed_code,
  output logic [NPORTS-1:0]   full_duplex
);

  localparam int unsigned PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [PORT_W-1:0]             cur_port;
  logic                          capture;
  logic [STAT_W-1:0]             masked;
  logic [STAT_W-1:0]             stored_cur;
  logic                          differs;
  logic [NPORTS-1:0][STAT_W-1:0] stat_all;

  assign masked  = mask_status(mdio_rdata);
  assign differs = (masked != stored_cur);

  pls_sequencer #(
    .NPORTS      (NPORTS),
    .IDLE_CYCLES (IDLE_CYCLES)
  ) i_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .scan_en        (scan_en),
    .mdio_done      (mdio_done),
    .reg_wr_ack     (reg_wr_ack),
    .status_differs (differs),
    .cur_port       (cur_port),
    .rd_active      (mdio_req),
    .wr_active      (reg_wr_req),
    .capture        (capture)
  );

  pls_status_file #(
    .NPORTS (NPORTS)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (capture && differs),
    .wr_port   (cur_port),
    .wr_status (masked),
    .rd_port   (cur_port),
    .rd_status (stored_cur),
    .stat_all  (stat_all)
  );

  pls_port_report #(
    .NPORTS (NPORTS)
  ) i_report (
    .stat_all    (stat_all),
    .link_up     (link_up),
    .speed_code  (speed_code),
    .full_duplex (full_duplex)
  );

  assign mdio_phy_addr = 5'(cur_port);
  assign mdio_reg_addr = PHY_STAT_REG;
  assign reg_wr_addr   = ADDR_W'({cur_port, SPEED_REG_OFS});
  // Store already holds the new status while the write is pending.
  assign reg_wr_data   = mode_value(stored_cur);

endmodule

// File: rtl/pls_checker.sv
module pls_checker #(
  parameter int unsigned NPORTS = 10,
  parameter int unsigned ADDR_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mdio_req,
  input logic [4:0]          mdio_phy_addr,
  input logic [4:0]          mdio_reg_addr,
  input logic                mdio_done,
  input logic                reg_wr_req,
  input logic [ADDR_W-1:0]   reg_wr_addr,
  input logic [15:0]         reg_wr_data,
  input logic                reg_wr_ack,
  input logic [NPORTS-1:0]   link_up,
  input logic [2*NPORTS-1:0] speed_code
);

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(mdio_req && reg_wr_req)); // R3

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && !mdio_done |=> mdio_req && $stable(mdio_phy_addr)); // R3

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_req && !reg_wr_ack |=> reg_wr_req && $stable(reg_wr_addr) && $stable(reg_wr_data)); // R3

  AST_READ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |-> (mdio_reg_addr == 5'h11) && (mdio_phy_addr < 5'(NPORTS))); // R2

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_wr_req) |-> $past(mdio_req && mdio_done)); // R7

  AST_WRITE_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_req |-> (reg_wr_addr[6:0] == 7'h10)
                   && (reg_wr_addr[ADDR_W-1:7] < (ADDR_W-7)'(NPORTS))
                   && (reg_wr_data == 16'h0003 || reg_wr_data == 16'h0001)); // R6

  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    AST_DOWN_IS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up[i] |-> speed_code[2*i +: 2] == 2'd2); // R8
  end

endmodule

bind phy_link_scanner pls_checker #(
  .NPORTS (NPORTS),
  .ADDR_W (ADDR_W)
) i_pls_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .mdio_req      (mdio_req),
  .mdio_phy_addr (mdio_phy_addr),
  .mdio_reg_addr (mdio_reg_addr),
  .mdio_done     (mdio_done),
  .reg_wr_req    (reg_wr_req),
  .reg_wr_addr   (reg_wr_addr),
  .reg_wr_data   (reg_wr_data),
  .reg_wr_ack    (reg_wr_ack),
  .link_up       (link_up),
  .speed_code    (speed_code)
);

// File: tb/test_phy_link_scanner.sv
`timescale 1ns/1ps
module test_phy_link_scanner;

  localparam int NP   = 10;
  localparam int IDLE = 12;
  localparam int AW   = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            scan_en;
  logic            mdio_req;
  logic [4:0]      mdio_phy_addr;
  logic [4:0]      mdio_reg_addr;
  logic            mdio_done;
  logic [15:0]     mdio_rdata;
  logic            reg_wr_req;
  logic [AW-1:0]   reg_wr_addr;
  logic [15:0]     reg_wr_data;
  logic            reg_wr_ack;
  logic [NP-1:0]   link_up;
  logic [2*NP-1:0] speed_code;
  logic [NP-1:0]   full_duplex;

  always #2.5 clk = ~clk;

  phy_link_scanner #(.NPORTS(NP), .IDLE_CYCLES(IDLE), .ADDR_W(AW)) i_phy_link_scanner (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
    .mdio_req(mdio_req), .mdio_phy_addr(mdio_phy_addr), .mdio_reg_addr(mdio_reg_addr),
    .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
    .reg_wr_req(reg_wr_req), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_wr_ack(reg_wr_ack),
    .link_up(link_up), .speed_code(speed_code), .full_duplex(full_duplex)
  );

  int          n_checks = 0;
  int          n_fail   = 0;
  bit          finished = 0;
  longint      cyc      = 0;
  logic [15:0] phy_stat [NP];
  logic [15:0] model    [NP];
  int          exp_port = 0;
  bit          exp_wr   = 0;
  logic [15:0] exp_wa, exp_wd;
  int          chk_port = -1;
  int          scans    = 0;
  int          n_writes = 0;
  longint      last_end = -1;
  int          rd_wait  = -1;
  int          wr_wait  = -1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] f_mask(input logic [15:0] r);
    return r[10] ? (r & 16'hE400) : 16'h0000;
  endfunction
  function automatic logic [15:0] f_mode(input logic [15:0] m);
    return (m[10] && !m[15]) ? 16'h0001 : 16'h0003;
  endfunction
  function automatic logic [1:0] f_spd(input logic [15:0] m);
    return (m[10] && !m[15]) ? 2'd1 : 2'd2;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  task automatic check_port_outputs(input int p);
    chk(link_up[p] == model[p][10], "R8 link", link_up[p], model[p][10]);
    chk(speed_code[2*p +: 2] == f_spd(model[p]), "R8 speed", speed_code[2*p +: 2], f_spd(model[p]));
    chk(full_duplex[p] == model[p][13], "R8 duplex", full_duplex[p], model[p][13]);
  endtask

  // Responder for the MDIO engine and the register bus
  initial begin
    mdio_done = 1'b0; reg_wr_ack = 1'b0; mdio_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (chk_port >= 0) begin
          check_port_outputs(chk_port);
          chk_port = -1;
        end
        mdio_done  = 1'b0;
        reg_wr_ack = 1'b0;
        if (mdio_req) begin
          if (rd_wait < 0) begin
            rd_wait = int'($urandom % 4);
            chk(!exp_wr, "R7 read while write owed", 1, 0);
            if (exp_port == 0 && last_end >= 0)
              chk(cyc - last_end > IDLE, "R9 gap", cyc - last_end, IDLE + 1);
          end
          if (rd_wait == 0) begin
            automatic int          p   = exp_port;
            automatic logic [15:0] raw = phy_stat[p] | (16'($urandom) & 16'h1BFF);
            automatic logic [15:0] m   = f_mask(raw);
            chk(mdio_phy_addr == 5'(p), "R2 phy addr", mdio_phy_addr, p);
            chk(mdio_reg_addr == 5'h11, "R2 reg addr", mdio_reg_addr, 5'h11);
            mdio_rdata = raw;
            mdio_done  = 1'b1;
            if (m != model[p]) begin
              exp_wr = 1;
              exp_wa = 16'((p << 7) | 16'h10);
              exp_wd = f_mode(m);
            end
            model[p] = m;
            chk_port = p;
            if (p == NP - 1 && !exp_wr) begin
              last_end = cyc;
              scans++;
            end
            exp_port = (p + 1) % NP;
            rd_wait  = -1;
          end else begin
            rd_wait--;
          end
        end
        if (reg_wr_req) begin
          if (wr_wait < 0) wr_wait = int'($urandom % 4);
          if (wr_wait == 0) begin
            chk(exp_wr, "R5 unexpected write", reg_wr_addr, 0);
            chk(reg_wr_addr == exp_wa, "R6 write addr", reg_wr_addr, exp_wa);
            chk(reg_wr_data == exp_wd, "R6 write data", reg_wr_data, exp_wd);
            exp_wr     = 0;
            reg_wr_ack = 1'b1;
            n_writes++;
            if (reg_wr_addr[15:7] == 9'(NP - 1)) begin
              last_end = cyc;
              scans++;
            end
            wr_wait = -1;
          end else begin
            wr_wait--;
          end
        end
      end
    end
  end

  task automatic wait_scans(input int n);
    automatic int target = scans + n;
    while (scans < target) @(posedge clk);
  endtask

  function automatic logic [15:0] pick_stat();
    automatic logic [15:0] r = 16'($urandom);
    case ($urandom % 5)
      0: return 16'h0000;
      1: return 16'h8400 | (r & 16'h2000);
      2: return 16'h4400 | (r & 16'h2000);
      3: return r & ~16'h0400;
      default: return r;
    endcase
  endfunction

  initial begin
    automatic int w0;
    automatic int wait_cyc;
    automatic int req_seen;
    automatic int scans0;
    void'($urandom(32'd4242));
    for (int i = 0; i < NP; i++) begin phy_stat[i] = '0; model[i] = '0; end
    rst_n = 1'b0; scan_en = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < NP; i++) begin
      chk(link_up[i] == 1'b0, "R1 link", link_up[i], 0);
      chk(speed_code[2*i +: 2] == 2'd2, "R1 speed", speed_code[2*i +: 2], 2);
      chk(full_duplex[i] == 1'b0, "R1 duplex", full_duplex[i], 0);
    end
    chk(!mdio_req && !reg_wr_req, "R1 no request", {mdio_req, reg_wr_req}, 0);
    rst_n = 1'b1;
    // R9: first scan starts without the pause
    wait_cyc = 0;
    while (!mdio_req && wait_cyc < 10) begin @(negedge clk); wait_cyc++; end
    chk(wait_cyc <= 2, "R9 first scan start", wait_cyc, 2);

    // R5: all links down, store starts at zero -> no writes
    w0 = n_writes;
    wait_scans(2);
    chk(n_writes == w0, "R5 no writes when unchanged", n_writes, w0);

    // R11 / R4: directed bring-up
    @(posedge clk);
    phy_stat[0] = 16'hA400;  // up, 1G, full
    phy_stat[1] = 16'h4400;  // up, 100M, half
    phy_stat[2] = 16'hE000;  // speed bits set but link bit clear -> zero
    phy_stat[3] = 16'hE400;  // reserved speed pair
    phy_stat[4] = 16'h6400;  // up, 100M, full
    w0 = n_writes;
    wait_scans(2);
    chk(n_writes == w0 + 4, "R11 first-up writes", n_writes, w0 + 4);
    chk(link_up[2] == 1'b0, "R4 dead link zero", link_up[2], 0);
    chk(speed_code[5:4] == 2'd2, "R4 dead link speed", speed_code[5:4], 2);
    w0 = n_writes;
    wait_scans(1);
    chk(n_writes == w0, "R5 stable repeat", n_writes, w0);

    // Link drop forces fast mode
    @(posedge clk);
    phy_stat[1] = 16'h0000;
    w0 = n_writes;
    wait_scans(2);
    chk(n_writes == w0 + 1, "R6 down write", n_writes, w0 + 1);

    // Random phase
    for (int it = 0; it < 40; it++) begin
      repeat ($urandom % 30) @(posedge clk);
      for (int k = 0; k < 1 + int'($urandom % 3); k++)
        phy_stat[$urandom % NP] = pick_stat();
      wait_scans(2);
    end

    // R10: disable mid-scan
    while (!(mdio_req && exp_port == 3)) @(posedge clk);
    scan_en = 1'b0;
    wait_scans(1);
    scans0 = scans;
    req_seen = 0;
    repeat (150) begin
      @(negedge clk);
      if (mdio_req || reg_wr_req) req_seen++;
    end
    chk(req_seen == 0, "R10 no scan while disabled", req_seen, 0);
    chk(scans == scans0, "R10 scan count frozen", scans, scans0);
    @(posedge clk);
    scan_en = 1'b1;
    phy_stat[7] = 16'h8400;
    wait_scans(2);
    chk(link_up[7] == 1'b1, "R10 resume", link_up[7], 1);

    finished = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", cyc, 0);
      summary();
    end
  end

endmodule